// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller for a successive-approximation analog-to-digital converter. It turns the system clock into a slower converter clock by issuing a one-cycle enable pulse at a programmable interval. It then takes each conversion through a fixed series of phases: a synchronizing wait, an input sampling window, the bit-by-bit conversion with its calibration overhead, and a short result-write slot. The analog comparator and the successive-approximation data path are not part of this block. It only supplies the strobes that pace them.

Software sets two 3-bit selects, one for the clock divide ratio and one for the sample window length, and then pulses a start input. The selects are copied into shadow registers when a start is accepted. They can therefore be rewritten at any time without disturbing the conversion in progress. Busy and done flags tell the system when the result has been written.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy_o, done_o, sample_o, convert_o, bit_step_o and write_o are all low.
- R2: The divide ratio N is set by div_sel_i: code k (0 to 7) gives N = 4*(8-k) system clocks per converter-clock period (32 for code 0 down to 4 for code 7). Within the conversion phase, consecutive bit_step_o pulses are exactly N system clocks apart.
- R3: The sample window follows smp_sel_i: code k gives 2*(k+1) converter-clock periods (2 for code 0 up to 16 for code 7). sample_o is high for exactly that count times N consecutive system clocks.
- R4: The phases occur in the strict order synchronize, sample, convert, write. At most one of sample_o, convert_o and write_o is high in any cycle.
- R5: The synchronizing phase is the time from the first busy cycle to the first sample_o cycle. It lasts between 1 and N system clocks.
- R6: convert_o is high for 18*N system clocks: 8 calibration periods followed by 10 bit periods. bit_step_o pulses for one cycle at the end of each of the last 10 periods, so pulse j (0 to 9) falls in convert cycle (9+j)*N-1, counting from 0. There are exactly 10 pulses per conversion.
- R7: write_o is high for exactly 2 system clocks, directly after the conversion phase.
- R8: done_o is high for exactly one cycle, in the cycle after the last write_o cycle. In that same cycle busy_o has already fallen.
- R9: A start_i pulse that arrives while busy_o is high is ignored. The running conversion keeps its timing, and no second conversion follows it.
- R10: Changing div_sel_i or smp_sel_i while busy does not alter the running conversion. The values present at the accepted start pulse are the ones used.
- R11: An accepted start makes busy_o high from the next cycle until the write phase ends. The total busy time is sync + sample + 18*N + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start pulse |
| div_sel_i | input | 3 | Converter clock divide select |
| smp_sel_i | input | 3 | Sample window length select |
| sample_o | output | 1 | High during the sample phase |
| convert_o | output | 1 | High during the conversion phase |
| bit_step_o | output | 1 | One-cycle strobe per converted bit |
| write_o | output | 1 | High during the result-write phase |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse after the write phase |

## Verification
The hardest situations to reach are the ones where inputs change while a conversion is running. These are a select rewrite that must not reach the phase counters, and a second start pulse that must be dropped. The bench handles both in the scenario tasks that measure the phases. One task rewrites both selects during the first sample cycle to very different values. Another pulses start in the middle of the conversion phase. Each then measures every phase length against the values latched at the accepted start, and then watches for a spurious second conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SYNC   = 3'd1,
    PH_SAMPLE = 3'd2,
    PH_CONV   = 3'd3,
    PH_WRITE  = 3'd4
  } phase_e;
endpackage

// File: rtl/adc_clk_div.sv
// Free-running divider: one-cycle tick every DIV_BASE*(2^SEL_W - sel) clocks.
module adc_clk_div #(
  parameter int SEL_W    = 3,
  parameter int DIV_BASE = 4,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NCODE = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = CNT_W'(DIV_BASE * (NCODE - int'(sel_i)) - 1);
    // >= so a shrunken ratio wraps at once instead of running to overflow
    tick_o = (cnt_q >= limit);
    cnt_d  = tick_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_cfg_shadow.sv
// Holds the selects captured when a start is accepted.
module adc_cfg_shadow #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] div_i,
  input  logic [SEL_W-1:0] smp_i,
  output logic [SEL_W-1:0] div_o,
  output logic [SEL_W-1:0] smp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o <= '0;
      smp_o <= '0;
    end else if (load_i) begin
      div_o <= div_i;
      smp_o <= smp_i;
    end
  end
endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
  import adc_seq_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int STC_BASE    = 2,
  parameter int DATA_BITS   = 10,
  parameter int CAL_PERIODS = 8,
  parameter int WRITE_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] smp_sel_i,
  output phase_e           phase_o,
  output logic             accept_o,
  output logic             step_o,
  output logic             done_o
);
  localparam int NCODE    = 1 << SEL_W;
  localparam int SMP_MAX  = STC_BASE * NCODE;
  localparam int CONV_LEN = DATA_BITS + CAL_PERIODS;
  localparam int PMAX_A   = (SMP_MAX > CONV_LEN) ? SMP_MAX : CONV_LEN;
  localparam int PMAX     = (PMAX_A > WRITE_CYC) ? PMAX_A : WRITE_CYC;
  localparam int PCNT_W   = $clog2(PMAX + 1);

  phase_e            ph_q, ph_d;
  logic [PCNT_W-1:0] k_q, k_d, smp_last;
  logic              done_d;

  always_comb begin
    smp_last = PCNT_W'(STC_BASE * (int'(smp_sel_i) + 1) - 1);
    accept_o = (ph_q == PH_IDLE) && start_i;
    step_o   = (ph_q == PH_CONV) && tick_i && (k_q >= PCNT_W'(CAL_PERIODS));
    ph_d     = ph_q;
    k_d      = k_q;
    done_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d = PH_SYNC;
        k_d  = '0;
      end
      PH_SYNC: if (tick_i) begin
        ph_d = PH_SAMPLE;
        k_d  = '0;
      end
      PH_SAMPLE: if (tick_i) begin
        if (k_q == smp_last) begin
          ph_d = PH_CONV;
          k_d  = '0;
        end else k_d = k_q + PCNT_W'(1);
      end
      PH_CONV: if (tick_i) begin
        if (k_q == PCNT_W'(CONV_LEN - 1)) begin
          ph_d = PH_WRITE;
          k_d  = '0;
        end else k_d = k_q + PCNT_W'(1);
      end
      PH_WRITE: begin
        if (k_q == PCNT_W'(WRITE_CYC - 1)) begin
          ph_d   = PH_IDLE;
          k_d    = '0;
          done_d = 1'b1;
        end else k_d = k_q + PCNT_W'(1);
      end
      default: begin
        ph_d = PH_IDLE;
        k_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      k_q    <= '0;
      done_o <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      k_q    <= k_d;
      done_o <= done_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int DIV_BASE    = 4,
  parameter int STC_BASE    = 2,
  parameter int DATA_BITS   = 10,
  parameter int CAL_PERIODS = 8,
  parameter int WRITE_CYC   = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [SEL_W-1:0] smp_sel_i,
  output logic             sample_o,
  output logic             convert_o,
  output logic             bit_step_o,
  output logic             write_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int NCODE = 1 << SEL_W;
  localparam int CNT_W = $clog2(DIV_BASE * NCODE);

  // reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_l = rst_pipe[RST_STAGES-1];

  logic             accept, tick;
  logic [SEL_W-1:0] div_sh, smp_sh;
  phase_e           phase;

  adc_cfg_shadow #(.SEL_W(SEL_W)) u_shadow (
    .clk(clk), .rst_n(rst_l), .load_i(accept),
    .div_i(div_sel_i), .smp_i(smp_sel_i),
    .div_o(div_sh), .smp_o(smp_sh)
  );

  adc_clk_div #(.SEL_W(SEL_W), .DIV_BASE(DIV_BASE), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_l), .sel_i(div_sh), .tick_o(tick)
  );

  adc_phase_fsm #(
    .SEL_W(SEL_W), .STC_BASE(STC_BASE), .DATA_BITS(DATA_BITS),
    .CAL_PERIODS(CAL_PERIODS), .WRITE_CYC(WRITE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_l), .start_i(start_i), .tick_i(tick),
    .smp_sel_i(smp_sh), .phase_o(phase), .accept_o(accept),
    .step_o(bit_step_o), .done_o(done_o)
  );

  always_comb begin
    sample_o  = (phase == PH_SAMPLE);
    convert_o = (phase == PH_CONV);
    write_o   = (phase == PH_WRITE);
    busy_o    = (phase != PH_IDLE);
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sample_o,
  input logic convert_o,
  input logic bit_step_o,
  input logic write_o,
  input logic busy_o,
  input logic done_o
);
  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_o, convert_o, write_o}));

  assert_step_in_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_step_o |-> convert_o);

  assert_write_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_o) |=> write_o);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(write_o) && !busy_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_phase_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o || convert_o || write_o) |-> busy_o);
endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_o(sample_o),
  .convert_o(convert_o), .bit_step_o(bit_step_o), .write_o(write_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  logic       clk, rst_n, start_i;
  logic [2:0] div_sel_i, smp_sel_i;
  logic       sample_o, convert_o, bit_step_o, write_o, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;

  adc_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .div_sel_i(div_sel_i), .smp_sel_i(smp_sel_i),
    .sample_o(sample_o), .convert_o(convert_o), .bit_step_o(bit_step_o),
    .write_o(write_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: plain; 1: rewrite selects in first sample cycle; 2: start during convert
  task automatic run_conv(input int dsel, input int ssel, input int mode);
    int n, s, syn, smp, cnv, wr, steps, stage, last_stage, guard;
    bit order_ok, seen_done;
    n = 4 * (8 - dsel);
    s = 2 * (ssel + 1);
    syn = 0; smp = 0; cnv = 0; wr = 0; steps = 0; last_stage = 0;
    order_ok = 1'b1; seen_done = 1'b0; guard = 0;
    @(negedge clk);
    div_sel_i = 3'(dsel);
    smp_sel_i = 3'(ssel);
    start_i   = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R11 busy after start", int'(busy_o), 1);
    while (!seen_done && guard < 3000) begin
      guard++;
      start_i = 1'b0;
      if (done_o) begin
        seen_done = 1'b1;
        chk(busy_o == 1'b0 && write_o == 1'b0, "R8 done with busy low",
            int'(busy_o), 0);
      end else begin
        if (write_o)        begin stage = 4; wr++; end
        else if (convert_o) begin
          stage = 3;
          if (bit_step_o) begin
            chk(cnv == (9 + steps) * n - 1, "R2 R6 bit step position", cnv,
                (9 + steps) * n - 1);
            steps++;
          end
          cnv++;
          if (mode == 2 && cnv == 3) start_i = 1'b1;
        end
        else if (sample_o)  begin
          stage = 2; smp++;
          if (mode == 1 && smp == 1) begin
            div_sel_i = 3'(7 - dsel);
            smp_sel_i = 3'(7 - ssel);
          end
        end
        else if (busy_o)    begin stage = 1; syn++; end
        else                begin stage = 0; order_ok = 1'b0; end
        if (stage < last_stage) order_ok = 1'b0;
        last_stage = stage;
      end
      @(negedge clk);
    end
    chk(seen_done, "R8 done seen", int'(seen_done), 1);
    chk(order_ok, "R4 phase order", int'(order_ok), 1);
    chk(syn >= 1 && syn <= n, "R5 sync length", syn, n);
    chk(smp == s * n, (mode == 1) ? "R10 R3 sample length" : "R3 sample length",
        smp, s * n);
    chk(cnv == 18 * n, (mode == 2) ? "R9 R6 convert length" : "R6 convert length",
        cnv, 18 * n);
    chk(steps == 10, "R6 step count", steps, 10);
    chk(wr == 2, "R7 write length", wr, 2);
    chk(syn + smp + cnv + wr == syn + s * n + 18 * n + 2, "R11 total busy",
        syn + smp + cnv + wr, syn + s * n + 18 * n + 2);
    // after done: no second pulse and no follow-on conversion
    for (int i = 0; i < 4; i++) begin
      chk(done_o == 1'b0, "R8 done single", int'(done_o), 0);
      chk(busy_o == 1'b0, (mode == 2) ? "R9 no restart" : "R11 idle after",
          int'(busy_o), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk({busy_o, done_o, sample_o, convert_o, bit_step_o, write_o} == 6'b0,
        "R1 reset outputs",
        int'({busy_o, done_o, sample_o, convert_o, bit_step_o, write_o}), 0);
  endtask

  task automatic t_default;     run_conv(0, 0, 0); endtask
  task automatic t_fast_long;   run_conv(7, 7, 0); endtask
  task automatic t_mid;         run_conv(3, 4, 0); endtask
  task automatic t_cfg_rewrite;
    run_conv(2, 1, 1);          // R10: rewrite lands mid-sample, ignored
    run_conv(5, 6, 0);          // R10: the new values take effect next time
  endtask
  task automatic t_busy_start;  run_conv(6, 2, 2); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; div_sel_i = '0; smp_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default();
    t_fast_long();
    t_mid();
    t_cfg_rewrite();
    t_busy_start();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule